// File: doc/BRIEF.md
# Multi-Channel Pulse Period and High-Time Meter

This block watches a set of asynchronous digital inputs and, for each one, measures how long a full cycle of the signal lasts and how long the signal stays high within that cycle. Both figures are whole counts of the block's own clock, so software converts them to time by dividing by the clock frequency. The block reports that frequency in a read-only register.

Each input passes through a two-flop synchroniser, and edges are detected on the synchronised level. Every rising edge closes one measurement and opens the next: the period count and the high-time count are captured together, and both counters restart at that edge. A counter that runs out of range stops at its largest value rather than wrapping. The first rising edge after a reset only arms the channel, because the stretch before it is not a complete cycle.

Software reads the results through a simple word-addressed register port. Periods and high times sit in two separate banks of 32-bit read-only registers. Writing a one to bit 0 of the control word clears every channel back to its reset state.

Top module: `pulse_meter`

## Requirements
- R1: After the reset input is released, every period and high-time register reads 0.
- R2: Channel c's period register sits at byte offset 0x24 + 4*c. Once a channel has seen two rising edges, this register holds the number of clock cycles between its two most recent rising edges.
- R3: Channel c's high-time register sits at byte offset 0x24 + 4*NUM_CH + 4*c. It holds the number of clock cycles the input was high within the period last captured, and it never exceeds that period.
- R4: The first rising edge after reset or after a software clear captures nothing. The channel's registers keep reading 0 until a second rising edge arrives.
- R5: A channel's results change only at one of its rising edges. While no rising edge arrives, repeated reads return the same values.
- R6: The internal counters are CNT_W bits wide and stop at 2^CNT_W - 1 instead of wrapping. A period or high time longer than that reads as 2^CNT_W - 1.
- R7: The register at byte offset 0x20 reads as the parameter BASE_CLK_HZ, the clock frequency in Hz.
- R8: A write to byte offset 0x00 with bit 0 set clears all counters, results and arming state in the same clock edge. A write there with bit 0 clear has no effect.
- R9: The control word (0x00), the status word (0x04) and every unmapped offset read as 0. Writes to any offset other than 0x00 are ignored.
- R10: Channels are independent. Activity on one input never changes another channel's results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; all counts are in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | NUM_CH | Asynchronous signals to be measured, one bit per channel |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte address for reads and writes; bits 1:0 are ignored |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the word at addr, combinational |

## Verification
The assertions assume that each input level lasts at least one clock cycle after synchronisation. They also assume that a soft clear never coincides with a rising edge in a way that matters: the clear has priority, so the edge is simply lost. The stimulus changes inputs only on falling clock edges and holds each level for a whole number of cycles, so every high and low phase has an exact expected length. Soft clears are issued only while all inputs are idle low. Saturation is reached by running the bench with an 8-bit counter, so phases of a few hundred cycles exceed the range.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_FREQ   = 2'd1,
    RD_PERIOD = 2'd2,
    RD_HIGH   = 2'd3
  } rdKind_e;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic rise;
    logic level;
  } edgeStrobe_t;

  // shared command from control to datapath
  typedef struct packed {
    logic    clear;
    rdKind_e rdKind;
  } ctlCmd_t;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chain[i] <= 1'b0;
        end else if (clear) begin
          chain[i] <= 1'b0;
        end else begin
          chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] sigIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output edgeStrobe_t       chStrb [NUM_CH],
  output ctlCmd_t           cmd,
  output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] rdIdx
);
  localparam int unsigned IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int          CFG_WORD  = 0;
  localparam int          STAT_WORD = 1;
  localparam int          FREQ_WORD = 8;
  localparam int          PER_BASE  = FREQ_WORD + 1;
  localparam int          HIGH_BASE = PER_BASE + int'(NUM_CH);
  localparam int          MAP_END   = HIGH_BASE + int'(NUM_CH);
  localparam int unsigned CLR_BIT   = 0;

  logic [ADDR_W-3:0] wordAddr;
  int                wordNum;
  int                rdOff;
  logic              unusedBits;

  assign wordAddr   = addr[ADDR_W-1:2];
  assign wordNum    = int'(wordAddr);
  assign unusedBits = ^{addr[1:0], wrData[REG_W-1:1]};

  // register decode
  always_comb begin
    cmd.rdKind = RD_ZERO;
    rdOff      = 0;
    if (wordNum == FREQ_WORD) begin
      cmd.rdKind = RD_FREQ;
    end else if (wordNum >= PER_BASE && wordNum < HIGH_BASE) begin
      cmd.rdKind = RD_PERIOD;
      rdOff      = wordNum - PER_BASE;
    end else if (wordNum >= HIGH_BASE && wordNum < MAP_END) begin
      cmd.rdKind = RD_HIGH;
      rdOff      = wordNum - HIGH_BASE;
    end
  end

  assign rdIdx     = IDX_W'(rdOff);
  assign cmd.clear = wrEn && (wordNum == CFG_WORD) && wrData[CLR_BIT];

  // input synchronisation and edge detection
  logic [NUM_CH-1:0] syncLvl;
  logic [NUM_CH-1:0] prevLvl;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rstN  (rstN),
        .clear (cmd.clear),
        .d     (sigIn[c]),
        .q     (syncLvl[c])
      );

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevLvl[c] <= 1'b0;
        end else if (cmd.clear) begin
          prevLvl[c] <= 1'b0;
        end else begin
          prevLvl[c] <= syncLvl[c];
        end
      end

      assign chStrb[c].rise  = syncLvl[c] & ~prevLvl[c];
      assign chStrb[c].level = syncLvl[c];
    end
  endgenerate

  AST_INDEX_IN_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdKind == RD_PERIOD || cmd.rdKind == RD_HIGH) |-> (int'(rdIdx) < int'(NUM_CH))); // R2

  AST_STATUS_DECODES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (wordNum == STAT_WORD || wordNum == CFG_WORD) |-> (cmd.rdKind == RD_ZERO)); // R9
endmodule

// File: rtl/pm_chan.sv
module pm_chan
  import pm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  edgeStrobe_t      strb,
  output logic [CNT_W-1:0] periodRes,
  output logic [CNT_W-1:0] highRes
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] hiCnt;
  logic             armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt    <= '0;
      hiCnt     <= '0;
      armed     <= 1'b0;
      periodRes <= '0;
      highRes   <= '0;
    end else if (clear) begin
      perCnt    <= '0;
      hiCnt     <= '0;
      armed     <= 1'b0;
      periodRes <= '0;
      highRes   <= '0;
    end else if (strb.rise) begin
      perCnt <= CNT_ONE;
      hiCnt  <= CNT_ONE;
      armed  <= 1'b1;
      if (armed) begin
        periodRes <= perCnt;
        highRes   <= hiCnt;
      end
    end else begin
      if (perCnt != CNT_MAX) perCnt <= perCnt + CNT_ONE;
      if (strb.level && hiCnt != CNT_MAX) hiCnt <= hiCnt + CNT_ONE;
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (perCnt == CNT_MAX && !strb.rise && !clear) |=> (perCnt == CNT_MAX)); // R6

  AST_HIGH_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    highRes <= periodRes); // R3

  AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rise && !clear) |=> ($stable(periodRes) && $stable(highRes))); // R5

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (periodRes == '0 && highRes == '0 && !armed)); // R8

  AST_FIRST_EDGE_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rise && !armed && !clear) |=> ($stable(periodRes) && armed)); // R4
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned BASE_CLK_HZ = 100_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  edgeStrobe_t      chStrb [NUM_CH],
  input  ctlCmd_t          cmd,
  input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] rdIdx,
  output logic [REG_W-1:0] rdData
);
  localparam logic [REG_W-1:0] FREQ_WORD = REG_W'(BASE_CLK_HZ);

  logic [CNT_W-1:0] periodArr [NUM_CH];
  logic [CNT_W-1:0] highArr   [NUM_CH];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pm_chan #(.CNT_W(CNT_W)) u_chan (
        .clk       (clk),
        .rstN      (rstN),
        .clear     (cmd.clear),
        .strb      (chStrb[c]),
        .periodRes (periodArr[c]),
        .highRes   (highArr[c])
      );
    end
  endgenerate

  always_comb begin
    rdData = '0;
    unique case (cmd.rdKind)
      RD_FREQ:   rdData = FREQ_WORD;
      RD_PERIOD: if (int'(rdIdx) < int'(NUM_CH)) rdData = REG_W'(periodArr[rdIdx]);
      RD_HIGH:   if (int'(rdIdx) < int'(NUM_CH)) rdData = REG_W'(highArr[rdIdx]);
      default:   rdData = '0;
    endcase
  end

  AST_FREQ_READOUT: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdKind == RD_FREQ) |-> (rdData == FREQ_WORD)); // R7

  AST_ZERO_READOUT: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdKind == RD_ZERO) |-> (rdData == '0)); // R9
endmodule

// File: rtl/pulse_meter.sv
module pulse_meter
  import pm_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] sigIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData
);
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  edgeStrobe_t      chStrb [NUM_CH];
  ctlCmd_t          cmd;
  logic [IDX_W-1:0] rdIdx;

  pm_ctrl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sigIn  (sigIn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .chStrb (chStrb),
    .cmd    (cmd),
    .rdIdx  (rdIdx)
  );

  pm_datapath #(
    .NUM_CH      (NUM_CH),
    .CNT_W       (CNT_W),
    .BASE_CLK_HZ (BASE_CLK_HZ)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .chStrb (chStrb),
    .cmd    (cmd),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );
endmodule

// File: tb/tb_pulse_meter.sv
module tb_pulse_meter;
  localparam int NUM_CH  = 2;
  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 8;
  localparam int FREQ_HZ = 50_000_000;
  localparam int SAT     = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NUM_CH-1:0] sigIn = '0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [31:0]       v;
    string             req;
  } expItem_t;

  expItem_t sbQ[$];

  always #5 clk = ~clk;

  pulse_meter #(
    .NUM_CH (NUM_CH), .CNT_W (CNT_W), .ADDR_W (ADDR_W), .BASE_CLK_HZ (FREQ_HZ)
  ) dut (
    .clk (clk), .rstN (rstN), .sigIn (sigIn), .wrEn (wrEn),
    .addr (addr), .wrData (wrData), .rdData (rdData)
  );

  function automatic logic [ADDR_W-1:0] perAddr(int ch);
    return ADDR_W'(8'h24 + 4 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] highAddr(int ch);
    return ADDR_W'(8'h24 + 4 * NUM_CH + 4 * ch);
  endfunction

  // driver side: push an expected register value
  task automatic expectReg(logic [ADDR_W-1:0] a, logic [31:0] v, string req);
    expItem_t it;
    it.a = a; it.v = v; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic expectChan(int ch, int per, int hi, string req);
    expectReg(perAddr(ch), 32'(per), req);
    expectReg(highAddr(ch), 32'(hi), req);
  endtask

  // monitor side: pop every pending item and compare with the design
  task automatic drainScoreboard();
    expItem_t it;
    while (sbQ.size() > 0) begin
      it = sbQ.pop_front();
      @(negedge clk);
      addr = it.a;
      #1;
      vectors++;
      if (rdData !== it.v) begin
        miscompares++;
        $display("FAIL %s addr=0x%02h actual=%0d expected=%0d", it.req, it.a, rdData, it.v);
      end
    end
  endtask

  task automatic regWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // arming rise, reps full periods, closing rise, then idle low
  task automatic runPulses(int ch, int hi, int lo, int reps);
    @(negedge clk);
    for (int r = 0; r < reps; r++) begin
      sigIn[ch] = 1'b1;
      repeat (hi) @(negedge clk);
      sigIn[ch] = 1'b0;
      repeat (lo) @(negedge clk);
    end
    sigIn[ch] = 1'b1;
    repeat (2) @(negedge clk);
    sigIn[ch] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    summary();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1: reset state of every result register
    for (int c = 0; c < NUM_CH; c++) expectChan(c, 0, 0, "R1 reset");
    // R7: frequency word
    expectReg(8'h20, 32'(FREQ_HZ), "R7 freq");
    // R9: control, status and unmapped words read zero
    expectReg(8'h00, 32'd0, "R9 ctrl reads 0");
    expectReg(8'h04, 32'd0, "R9 status reads 0");
    expectReg(8'h3C, 32'd0, "R9 unmapped reads 0");
    drainScoreboard();

    // R4: a single rise only arms the channel
    @(negedge clk); sigIn[0] = 1'b1; idle(4); sigIn[0] = 1'b0; idle(10);
    expectChan(0, 0, 0, "R4 first rise arms only");
    drainScoreboard();

    // R2 R3 R10: both channels at once with different shapes
    fork
      runPulses(0, 3, 5, 3);
      runPulses(1, 7, 2, 2);
    join
    idle(10);
    expectChan(0, 8, 3, "R2 R3 ch0 period/high");
    expectChan(1, 9, 7, "R2 R3 ch1 period/high");
    drainScoreboard();

    // R5: no edges, values hold
    idle(60);
    expectChan(0, 8, 3, "R5 hold ch0");
    expectChan(1, 9, 7, "R5 hold ch1");
    drainScoreboard();

    // R10: ch0 changes, ch1 untouched; narrowest pulses
    runPulses(0, 1, 1, 4);
    idle(10);
    expectChan(0, 2, 1, "R2 R3 ch0 narrow");
    expectChan(1, 9, 7, "R10 ch1 unaffected");
    drainScoreboard();

    // R9 R8: writes that must have no effect
    regWrite(8'h04, 32'hFFFF_FFFF);
    regWrite(8'h24, 32'hFFFF_FFFF);
    regWrite(8'h00, 32'hFFFF_FFFE);
    idle(3);
    expectChan(0, 2, 1, "R8 R9 ignored writes ch0");
    expectChan(1, 9, 7, "R8 R9 ignored writes ch1");
    drainScoreboard();

    // R8: soft clear
    regWrite(8'h00, 32'h0000_0001);
    idle(2);
    expectChan(0, 0, 0, "R8 clear ch0");
    expectChan(1, 0, 0, "R8 clear ch1");
    drainScoreboard();

    // R4: after clear the first rise arms only
    @(negedge clk); sigIn[1] = 1'b1; idle(3); sigIn[1] = 1'b0; idle(10);
    expectChan(1, 0, 0, "R4 arm after clear");
    drainScoreboard();
    runPulses(1, 4, 4, 1);
    idle(10);
    expectChan(1, 8, 4, "R2 R3 after clear");
    drainScoreboard();

    // R6: saturation of both counters, then of the period alone
    runPulses(0, 300, 5, 1);
    idle(10);
    expectChan(0, SAT, SAT, "R6 saturate both");
    drainScoreboard();
    runPulses(0, 2, 300, 1);
    idle(10);
    expectChan(0, SAT, 2, "R6 saturate period");
    drainScoreboard();

    summary();
  end
endmodule